// File: doc/BRIEF.md
# Strap-Configured Dual-Protocol Host Port

This block is the slave side of a parallel bus through which an external microcontroller reaches a small register bank and a byte-wide code port. Three strap inputs, captured only while reset is held, fix the data bus width (8 or 16 bits), which lane carries the most significant byte in 16-bit mode, and the strobe protocol. In protocol A the host gives a direction level and one active-low data strobe. In protocol B it uses separate active-low write and read strobes. The chip select and the strobes pass through a two-flop synchroniser, and an access starts on the synchronised falling edge of the strobe.

Code bytes written to the code port go into a 16-entry byte FIFO that the decoding engine drains through a show-ahead pop interface. A ready output tells the host when it may stream bytes without polling. A maskable interrupt request reports event pulses from the engine. The acknowledge, ready and interrupt pins are modelled as open-drain style outputs: a level and an output enable. To deassert, the pin drives the inactive (high) level for one cycle and then releases.

Top module: `strap_host_port`

## Requirements
- R1: Straps are captured on every clock edge while `rst_n` is low. Once reset is released, later strap changes have no effect on width, byte order or protocol.
- R2: With `strap_wide` low, only `hs_din[7:0]` and `hs_dout[7:0]` carry data, and `hs_oe_hi` stays low. A code-port write pushes one byte.
- R3: With `strap_wide` high, `strap_swap` low puts the most significant byte on bits 15:8 of the lanes, and `strap_swap` high puts it on bits 7:0. This holds for both reads and writes.
- R4: In protocol A (`strap_protb` low), an access starts when `hs_strb` falls while `hs_cs_n` is low. `hs_dirwr` high means read and low means write. `ack_lvl` is driven low from the start of the access while the strobe stays low.
- R5: In protocol B (`strap_protb` high), a falling `hs_dirwr` starts a write and a falling `hs_strb` starts a read. Each access drives `ack_lvl` low for exactly one cycle, as a wait indication.
- R6: The register addresses are as follows. Address 0 is the write-only code port. Address 1 is the event status register; reading it clears it. Address 2 is the event enable mask, with the low 4 bits read/write. Address 3 is the read-only FIFO free-entry count. Other addresses read as 0. Writes to addresses 1, 3 and the unused addresses change nothing.
- R7: An event pulse sets its status bit whether or not the bit is enabled. The interrupt drives `irq_lvl` low while any status bit is both set and enabled. It is cleared by reading the status register, by clearing the enable, or by reset.
- R8: Code bytes leave the FIFO in the order they were written. A 16-bit write pushes the most significant byte first.
- R9: Ready is released while more than 2 entries are free, and driven low when 2 or fewer are free. Two more bytes are still accepted after ready goes low. Bytes written when the FIFO is full are dropped.
- R10: Deasserting acknowledge, ready or interrupt drives the level high for one cycle and then drops the output enable.
- R11: No access takes place while `hs_cs_n` is high. The read data lanes are driven only during a read with chip select low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low synchronous reset; straps are captured while low |
| strap_wide | input | 1 | Bus width strap: 0 = 8-bit, 1 = 16-bit |
| strap_swap | input | 1 | Byte order strap for 16-bit mode: 1 = MSB on low lane |
| strap_protb | input | 1 | Protocol strap: 0 = type A, 1 = type B |
| hs_cs_n | input | 1 | Active-low chip select |
| hs_adr | input | 4 | Register address |
| hs_dirwr | input | 1 | Type A: direction (1 = read); type B: active-low write strobe |
| hs_strb | input | 1 | Type A: active-low data strobe; type B: active-low read strobe |
| hs_din | input | 16 | Host write data lanes |
| hs_dout | output | 16 | Host read data lanes |
| hs_oe_lo | output | 1 | Drive enable for lanes 7:0 |
| hs_oe_hi | output | 1 | Drive enable for lanes 15:8 |
| ack_lvl | output | 1 | Acknowledge/wait level (active low) |
| ack_oe | output | 1 | Acknowledge drive enable |
| rdy_lvl | output | 1 | Ready level (low = stop streaming) |
| rdy_oe | output | 1 | Ready drive enable |
| irq_lvl | output | 1 | Interrupt request level (active low) |
| irq_oe | output | 1 | Interrupt drive enable |
| evt_i | input | 4 | Event pulses from the engine |
| code_pop | input | 1 | Engine takes the head code byte |
| code_byte | output | 8 | Head code byte |
| code_avail | output | 1 | FIFO not empty |

## Verification
The hardest case to reach from the ports is the ready boundary. The host must keep writing after ready has been pulled low and must see exactly two more bytes accepted, while the engine side stays idle. The stimulus fills the FIFO with single-byte writes until ready drops at two free entries, writes two more, and then writes one extra that must be dropped. It then pops every byte and compares the order, and repeats the fill with 16-bit writes. A second hard case is a strap change after reset. The bench flips the width and byte-order straps mid-run and shows through the popped byte order that the latched configuration still applies.

// File: rtl/hp_pkg.sv
package hp_pkg;
  localparam int BUSW  = 16;
  localparam int ADR_W = 4;

  localparam logic [ADR_W-1:0] RA_CODE = 4'd0;
  localparam logic [ADR_W-1:0] RA_STAT = 4'd1;
  localparam logic [ADR_W-1:0] RA_MASK = 4'd2;
  localparam logic [ADR_W-1:0] RA_FREE = 4'd3;

  typedef struct packed {
    logic wide;
    logic swap;
    logic protb;
  } strap_t;

  // host lanes -> logical value (MSB in [15:8])
  function automatic logic [BUSW-1:0] lanes_to_val(input logic [BUSW-1:0] d, input strap_t c);
    if (!c.wide)     return {8'h00, d[7:0]};
    else if (c.swap) return {d[7:0], d[15:8]};
    else             return d;
  endfunction

  // logical value -> host lanes
  function automatic logic [BUSW-1:0] val_to_lanes(input logic [BUSW-1:0] v, input strap_t c);
    if (!c.wide)     return {8'h00, v[7:0]};
    else if (c.swap) return {v[7:0], v[15:8]};
    else             return v;
  endfunction
endpackage

// File: rtl/hp_sync.sv
module hp_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta <= '1;
      q    <= '1;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/hp_odrv.sv
module hp_odrv (
  input  logic clk,
  input  logic rst_n,
  input  logic act,
  output logic lvl,
  output logic oe
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl <= 1'b1;
      oe  <= 1'b0;
    end else if (act) begin
      lvl <= 1'b0;
      oe  <= 1'b1;
    end else if (oe && !lvl) begin
      lvl <= 1'b1;
    end else begin
      lvl <= 1'b1;
      oe  <= 1'b0;
    end
  end

  // R10: the high-drive phase lasts a single cycle
  a_r10_one_high: assert property (@(posedge clk) disable iff (!rst_n)
    (oe && lvl) |=> !(oe && lvl));
endmodule

// File: rtl/hp_fifo.sv
module hp_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int FW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    push_n,
  input  logic [DW-1:0] b0,
  input  logic [DW-1:0] b1,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic          avail,
  output logic [FW-1:0] free
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [FW-1:0] cnt;
  logic [1:0]    acc;
  logic          pop_ok;

  assign free   = FW'(DEPTH) - cnt;
  assign pop_ok = pop && (cnt != '0);
  assign avail  = (cnt != '0);
  assign head   = mem[rp];

  always_comb begin
    if ({{(FW-2){1'b0}}, push_n} > free) acc = free[1:0];
    else                                 acc = push_n;
  end

  always_ff @(posedge clk) begin
    if (acc != 2'd0) mem[wp] <= b0;
    if (acc == 2'd2) mem[wp + AW'(1)] <= b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      wp  <= wp + AW'(acc);
      rp  <= rp + AW'(pop_ok);
      cnt <= cnt + FW'(acc) - FW'(pop_ok);
    end
  end

  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FW'(DEPTH));
  a_r9_full_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == FW'(DEPTH) && !pop) |=> (cnt == FW'(DEPTH)));
endmodule

// File: rtl/hp_regs.sv
module hp_regs
  import hp_pkg::*;
#(
  parameter int NEVT = 4,
  parameter int FW   = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wide,
  input  logic             wr_evt,
  input  logic             rd_evt,
  input  logic [ADR_W-1:0] adr,
  input  logic [BUSW-1:0]  wval,
  input  logic [NEVT-1:0]  evt,
  input  logic [FW-1:0]    free,
  output logic [BUSW-1:0]  rval,
  output logic             irq_act,
  output logic [1:0]       push_n,
  output logic [7:0]       pb0,
  output logic [7:0]       pb1
);
  logic [NEVT-1:0] status, mask;
  logic            stat_rd, code_wr;

  assign stat_rd = rd_evt && (adr == RA_STAT);
  assign code_wr = wr_evt && (adr == RA_CODE);
  assign irq_act = |(status & mask);

  assign push_n = !code_wr ? 2'd0 : (wide ? 2'd2 : 2'd1);
  assign pb0    = wide ? wval[15:8] : wval[7:0];
  assign pb1    = wval[7:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status <= '0;
      mask   <= '0;
      rval   <= '0;
    end else begin
      status <= (stat_rd ? '0 : status) | evt;
      if (wr_evt && adr == RA_MASK) mask <= wval[NEVT-1:0];
      if (rd_evt) begin
        case (adr)
          RA_STAT: rval <= BUSW'(status);
          RA_MASK: rval <= BUSW'(mask);
          RA_FREE: rval <= BUSW'(free);
          default: rval <= '0;
        endcase
      end
    end
  end

  // R7: a status read with no new event leaves no pending request
  a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && evt == '0) |=> !irq_act);
  a_r7_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |=> ((status & $past(evt)) == $past(evt)));
endmodule

// File: rtl/strap_host_port.sv
module strap_host_port
  import hp_pkg::*;
#(
  parameter int NEVT     = 4,
  parameter int DEPTH    = 16,
  parameter int LOW_MARK = 2,
  localparam int FW      = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strap_wide,
  input  logic             strap_swap,
  input  logic             strap_protb,
  input  logic             hs_cs_n,
  input  logic [ADR_W-1:0] hs_adr,
  input  logic             hs_dirwr,
  input  logic             hs_strb,
  input  logic [BUSW-1:0]  hs_din,
  output logic [BUSW-1:0]  hs_dout,
  output logic             hs_oe_lo,
  output logic             hs_oe_hi,
  output logic             ack_lvl,
  output logic             ack_oe,
  output logic             rdy_lvl,
  output logic             rdy_oe,
  output logic             irq_lvl,
  output logic             irq_oe,
  input  logic [NEVT-1:0]  evt_i,
  input  logic             code_pop,
  output logic [7:0]       code_byte,
  output logic             code_avail
);
  strap_t cfg;
  always_ff @(posedge clk) begin
    if (!rst_n) cfg <= '{wide: strap_wide, swap: strap_swap, protb: strap_protb};
  end

  // synchronised host controls
  logic s_cs, s_dw, s_st, p_dw, p_st;
  hp_sync #(.W(3)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({hs_cs_n, hs_dirwr, hs_strb}),
    .q({s_cs, s_dw, s_st})
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p_dw <= 1'b1;
      p_st <= 1'b1;
    end else begin
      p_dw <= s_dw;
      p_st <= s_st;
    end
  end

  // named access events
  logic dw_fall, st_fall, rd_evt, wr_evt, acc_evt;
  assign dw_fall = p_dw && !s_dw;
  assign st_fall = p_st && !s_st;
  assign rd_evt  = !s_cs && st_fall && (cfg.protb || s_dw);
  assign wr_evt  = !s_cs && (cfg.protb ? (dw_fall && !st_fall) : (st_fall && !s_dw));
  assign acc_evt = rd_evt || wr_evt;

  logic a_busy, rd_win;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_busy <= 1'b0;
      rd_win <= 1'b0;
    end else begin
      if (acc_evt && !cfg.protb) a_busy <= 1'b1;
      else if (s_st)             a_busy <= 1'b0;
      if (rd_evt)             rd_win <= 1'b1;
      else if (s_st || s_cs)  rd_win <= 1'b0;
    end
  end

  logic [BUSW-1:0] wval, rval;
  logic [FW-1:0]   free;
  logic [1:0]      push_n;
  logic [7:0]      pb0, pb1;
  logic            irq_act, ack_act, rdy_act;

  assign wval = lanes_to_val(hs_din, cfg);

  hp_regs #(.NEVT(NEVT), .FW(FW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wide(cfg.wide),
    .wr_evt(wr_evt), .rd_evt(rd_evt), .adr(hs_adr), .wval(wval),
    .evt(evt_i), .free(free), .rval(rval), .irq_act(irq_act),
    .push_n(push_n), .pb0(pb0), .pb1(pb1)
  );

  hp_fifo #(.DW(8), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push_n(push_n), .b0(pb0), .b1(pb1),
    .pop(code_pop), .head(code_byte), .avail(code_avail), .free(free)
  );

  assign hs_dout  = val_to_lanes(rval, cfg);
  assign hs_oe_lo = rd_win;
  assign hs_oe_hi = rd_win && cfg.wide;

  assign ack_act = acc_evt || (!cfg.protb && a_busy && !s_st);
  assign rdy_act = (free <= FW'(LOW_MARK));

  hp_odrv u_ack (.clk(clk), .rst_n(rst_n), .act(ack_act), .lvl(ack_lvl), .oe(ack_oe));
  hp_odrv u_rdy (.clk(clk), .rst_n(rst_n), .act(rdy_act), .lvl(rdy_lvl), .oe(rdy_oe));
  hp_odrv u_irq (.clk(clk), .rst_n(rst_n), .act(irq_act), .lvl(irq_lvl), .oe(irq_oe));

  a_r1_straps_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(cfg));
  a_r2_narrow_lane: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg.wide |-> !hs_oe_hi);
  a_r4_ack_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg.protb && a_busy && !s_st) |=> (ack_oe && !ack_lvl));
  a_r5_wait_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.protb && ack_oe && !ack_lvl) |=> !(ack_oe && !ack_lvl));
  a_r5_one_kind: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_evt, wr_evt}));
  a_r9_ready_low: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(free) <= FW'(LOW_MARK)) |-> (rdy_oe && !rdy_lvl));
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    s_cs |=> !hs_oe_lo);
endmodule

// File: tb/strap_host_port_tb.sv
module strap_host_port_tb;
  localparam int CLK_P = 10;
  localparam int HOLD  = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strap_wide = 1'b0, strap_swap = 1'b0, strap_protb = 1'b0;
  logic hs_cs_n = 1'b1, hs_dirwr = 1'b1, hs_strb = 1'b1;
  logic [3:0]  hs_adr = '0;
  logic [15:0] hs_din = '0;
  logic [15:0] hs_dout;
  logic hs_oe_lo, hs_oe_hi, ack_lvl, ack_oe, rdy_lvl, rdy_oe, irq_lvl, irq_oe;
  logic [3:0] evt_i = '0;
  logic code_pop = 1'b0;
  logic [7:0] code_byte;
  logic code_avail;

  always #(CLK_P/2) clk = ~clk;

  strap_host_port u_dut (
    .clk(clk), .rst_n(rst_n), .strap_wide(strap_wide), .strap_swap(strap_swap),
    .strap_protb(strap_protb), .hs_cs_n(hs_cs_n), .hs_adr(hs_adr),
    .hs_dirwr(hs_dirwr), .hs_strb(hs_strb), .hs_din(hs_din), .hs_dout(hs_dout),
    .hs_oe_lo(hs_oe_lo), .hs_oe_hi(hs_oe_hi), .ack_lvl(ack_lvl), .ack_oe(ack_oe),
    .rdy_lvl(rdy_lvl), .rdy_oe(rdy_oe), .irq_lvl(irq_lvl), .irq_oe(irq_oe),
    .evt_i(evt_i), .code_pop(code_pop), .code_byte(code_byte), .code_avail(code_avail)
  );

  int n_chk = 0, n_bad = 0, ack_low = 0;
  bit m_wide = 0, m_swap = 0, m_protb = 0;
  bit oe_hi_seen = 0;
  logic [15:0] raw_seen;

  always @(negedge clk) if (ack_oe && !ack_lvl) ack_low++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] put_lanes(input logic [15:0] v);
    if (!m_wide) return {8'h00, v[7:0]};
    return m_swap ? {v[7:0], v[15:8]} : v;
  endfunction

  function automatic logic [15:0] get_lanes(input logic [15:0] d);
    if (!m_wide) return {8'h00, d[7:0]};
    return m_swap ? {d[7:0], d[15:8]} : d;
  endfunction

  function automatic bit is_ready();
    return !(rdy_oe && !rdy_lvl);
  endfunction

  task automatic do_reset(input bit w, input bit s, input bit b);
    @(negedge clk);
    rst_n = 1'b0; strap_wide = w; strap_swap = s; strap_protb = b;
    m_wide = w; m_swap = s; m_protb = b;
    hs_cs_n = 1'b1; hs_dirwr = 1'b1; hs_strb = 1'b1; evt_i = '0; code_pop = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic bus_write_raw(input logic [3:0] a, input logic [15:0] raw, input bit use_cs);
    @(negedge clk);
    hs_adr = a; hs_din = raw; hs_cs_n = !use_cs;
    if (!m_protb) hs_dirwr = 1'b0;
    @(negedge clk);
    ack_low = 0;
    if (m_protb) hs_dirwr = 1'b0; else hs_strb = 1'b0;
    repeat (HOLD) @(negedge clk);
    if (m_protb) hs_dirwr = 1'b1; else hs_strb = 1'b1;
    repeat (5) @(negedge clk);
    hs_cs_n = 1'b1; hs_dirwr = 1'b1;
    @(negedge clk);
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [15:0] v);
    bus_write_raw(a, put_lanes(v), 1'b1);
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [15:0] v);
    @(negedge clk);
    hs_adr = a; hs_cs_n = 1'b0; hs_dirwr = 1'b1;
    @(negedge clk);
    ack_low = 0;
    hs_strb = 1'b0;
    repeat (HOLD) @(negedge clk);
    raw_seen = hs_dout;
    v = get_lanes(hs_dout);
    oe_hi_seen = hs_oe_hi;
    chk(hs_oe_lo == 1'b1, "R11 read drives lanes", hs_oe_lo, 1);
    hs_strb = 1'b1;
    repeat (5) @(negedge clk);
    hs_cs_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic pulse_evt(input logic [3:0] e);
    @(negedge clk); evt_i = e;
    @(negedge clk); evt_i = '0;
    repeat (4) @(negedge clk);
  endtask

  task automatic pop_chk(input logic [7:0] exp, input string req);
    @(negedge clk);
    chk(code_avail && code_byte == exp, req, code_byte, exp);
    code_pop = 1'b1;
    @(negedge clk);
    code_pop = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] rv;
    logic [7:0]  q[$];
    void'($urandom(32'h5eed_1234));

    // ---- 8-bit, protocol A ----
    do_reset(0, 0, 0);
    chk(!irq_oe && !ack_oe && !hs_oe_lo, "R10 reset outputs released", {irq_oe, ack_oe, hs_oe_lo}, 0);
    chk(is_ready() && !code_avail, "R9 reset ready and empty", {is_ready(), code_avail}, 2);
    bus_read(4'd3, rv);
    chk(rv == 16'd16, "R6 free count after reset", rv, 16);
    chk(!oe_hi_seen, "R2 high lane idle in 8-bit", oe_hi_seen, 0);
    bus_write(4'd2, 16'h005A);
    chk(ack_low >= 3, "R4 ack held during strobe", ack_low, 3);
    chk(!ack_oe, "R10 ack released after access", ack_oe, 0);
    bus_read(4'd2, rv);
    chk(rv == 16'h000A, "R6 mask readback low 4 bits", rv, 16'hA);
    bus_write_raw(4'd2, 16'h0003, 1'b0);
    bus_read(4'd2, rv);
    chk(rv == 16'h000A, "R11 write without chip select ignored", rv, 16'hA);

    pulse_evt(4'b0010);
    chk(irq_oe && !irq_lvl, "R7 enabled event raises request", {irq_oe, irq_lvl}, 2);
    bus_read(4'd1, rv);
    chk(rv == 16'h0002, "R7 status value", rv, 2);
    chk(!irq_oe, "R7 R10 status read releases request", irq_oe, 0);
    pulse_evt(4'b0001);
    chk(!irq_oe, "R7 masked event no request", irq_oe, 0);
    bus_write(4'd1, 16'h0000);
    bus_read(4'd1, rv);
    chk(rv == 16'h0001, "R7 R6 masked event sets status, write ignored", rv, 1);
    pulse_evt(4'b1000);
    chk(irq_oe && !irq_lvl, "R7 second enabled event", {irq_oe, irq_lvl}, 2);
    bus_write(4'd2, 16'h0000);
    repeat (3) @(negedge clk);
    chk(!irq_oe, "R7 disabling mask clears request", irq_oe, 0);
    bus_read(4'd1, rv);
    chk(rv == 16'h0008, "R7 status kept after mask clear", rv, 8);
    bus_read(4'd7, rv);
    chk(rv == 16'h0000, "R6 unused address reads zero", rv, 0);

    // ---- ready boundary, 8-bit ----
    q.delete();
    for (int i = 0; i < 13; i++) begin
      logic [7:0] b = 8'($urandom);
      q.push_back(b);
      bus_write(4'd0, {8'h00, b});
    end
    chk(is_ready(), "R9 ready released with 3 free", is_ready(), 1);
    q.push_back(8'hC3); bus_write(4'd0, 16'h00C3);
    chk(!is_ready(), "R9 ready low with 2 free", is_ready(), 0);
    q.push_back(8'h5D); bus_write(4'd0, 16'h005D);
    q.push_back(8'hE7); bus_write(4'd0, 16'h00E7);
    bus_write(4'd0, 16'h0099);
    bus_write(4'd3, 16'h0000);
    bus_read(4'd3, rv);
    chk(rv == 16'd0, "R9 R6 two extra accepted, overflow dropped", rv, 0);
    foreach (q[i]) pop_chk(q[i], "R8 R9 byte order after fill");
    @(negedge clk);
    chk(!code_avail, "R9 dropped byte absent", code_avail, 0);

    // ---- 16-bit, protocol B, normal order ----
    do_reset(1, 0, 1);
    bus_write(4'd0, 16'hA1B2);
    chk(ack_low == 1, "R5 single wait cycle", ack_low, 1);
    pop_chk(8'hA1, "R8 16-bit MSB first");
    pop_chk(8'hB2, "R8 16-bit LSB second");
    bus_write(4'd2, 16'h000C);
    bus_read(4'd2, rv);
    chk(raw_seen == 16'h000C, "R3 normal order read lanes", raw_seen, 16'h000C);
    chk(ack_low == 1, "R5 read wait cycle", ack_low, 1);
    chk(oe_hi_seen, "R2 high lane driven in 16-bit", oe_hi_seen, 1);

    // ---- 16-bit, protocol A, swapped order ----
    do_reset(1, 1, 0);
    bus_write_raw(4'd0, 16'h1122, 1'b1);
    pop_chk(8'h22, "R3 swapped MSB on low lane");
    pop_chk(8'h11, "R3 swapped LSB on high lane");
    bus_write(4'd2, 16'h0005);
    bus_read(4'd2, rv);
    chk(raw_seen == 16'h0500, "R3 swapped read lanes", raw_seen, 16'h0500);
    strap_wide = 1'b0; strap_swap = 1'b0; strap_protb = 1'b1;
    bus_write_raw(4'd0, 16'h3344, 1'b1);
    pop_chk(8'h44, "R1 straps ignored after reset (first)");
    pop_chk(8'h33, "R1 straps ignored after reset (second)");

    // ---- ready boundary, 16-bit writes ----
    do_reset(1, 0, 1);
    q.delete();
    for (int i = 0; i < 7; i++) begin
      logic [15:0] v = 16'($urandom);
      q.push_back(v[15:8]); q.push_back(v[7:0]);
      bus_write(4'd0, v);
    end
    chk(!is_ready(), "R9 ready low after 14 bytes", is_ready(), 0);
    q.push_back(8'h6A); q.push_back(8'h7B);
    bus_write(4'd0, 16'h6A7B);
    foreach (q[i]) pop_chk(q[i], "R9 R8 16-bit fill order");
    repeat (3) @(negedge clk);
    chk(is_ready() && !rdy_oe, "R10 ready released after drain", rdy_oe, 0);

    // ---- random phase ----
    for (int m = 0; m < 5; m++) begin
      bit w = (m >= 2);
      do_reset(w, (m == 4), m[0]);
      for (int k = 0; k < 6; k++) begin
        logic [15:0] v = 16'($urandom);
        logic [3:0]  mk = 4'($urandom);
        bus_write(4'd2, {12'h000, mk});
        bus_read(4'd2, rv);
        chk(rv == {12'h000, mk}, "R6 random mask readback", rv, mk);
        bus_write(4'd0, v);
        if (w) begin
          pop_chk(v[15:8], "R8 random 16-bit first");
          pop_chk(v[7:0], "R8 random 16-bit second");
        end else begin
          pop_chk(v[7:0], "R2 random 8-bit byte");
        end
      end
    end

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end
endmodule